// File: doc/BRIEF.md
# E1 Receive Performance Error Counters

This block keeps four error tallies for one E1 receive path. The four tallies are line violations, CRC4 code-word errors, far-end block errors and frame-alignment word errors. The event detectors upstream raise a one-cycle strobe per event. Along with the line-violation strobe they give the polarity of the offending pulse. The block also receives a CRC4 multiframe sync flag, a once-per-frame tick and two mode inputs.

An interval timer counts frame ticks. At the end of each interval, every running count is copied into a holding register that a host reads at leisure, and the running count restarts. There are two interval lengths: a long one (one second at 8000 frames per second) and a short one (62.5 ms, 500 frames).

The violation tally has two modes:
- It counts every violation.
- It counts only code violations. A code violation is a violation whose polarity matches the violation before it.

Each running count stops at its maximum value instead of wrapping.

Top module: `e1_perf_counters`

## Requirements
- R1: While `rst_n` is low, and after reset until the first interval ends, all four count outputs read zero.
- R2: With `cv_mode` = 0, every cycle in which `viol_stb` = 1 adds one to the violation count.
- R3: With `cv_mode` = 1, a `viol_stb` adds one only if an earlier violation strobe has been seen since reset and the polarity of that earlier strobe equals the current `viol_neg` (1 = negative pulse, 0 = positive). The stored polarity is updated on every violation strobe, in either mode.
- R4: The violation count and the alignment-word error count accumulate whatever the value of `crc_mf_sync`.
- R5: While `crc_mf_sync` = 0, strobes on `crc_err_stb` and `ebit_err_stb` are ignored. Both counts still latch and restart at interval ends.
- R6: With `short_intv` = 0 an interval is LONG_FRAMES frame ticks; with `short_intv` = 1 it is SHORT_FRAMES ticks. Timing starts from reset or from the previous interval end. The interval ends on the clock edge that samples the completing `frame_tick`. The four outputs show the copied counts from the following cycle and hold them until the next interval end.
- R7: At an interval end the running counts restart. An event strobed in the same cycle as the interval end is counted in the new interval.
- R8: Each running count saturates at its all-ones value (widths VIOL_W = 16, CRC_W = 10, EBIT_W = 10, FAS_W = 12 by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| short_intv | input | 1 | 0 = long interval, 1 = short interval |
| cv_mode | input | 1 | 0 = count every violation, 1 = count same-polarity pairs only |
| crc_mf_sync | input | 1 | 1 = CRC4 multiframe alignment held |
| viol_stb | input | 1 | Line violation seen this cycle |
| viol_neg | input | 1 | Polarity of that violation, 1 = negative |
| crc_err_stb | input | 1 | CRC4 code-word error seen |
| ebit_err_stb | input | 1 | Far-end error bit received |
| fas_err_stb | input | 1 | Alignment word received in error |
| viol_cnt | output | VIOL_W | Latched violation count |
| crc_cnt | output | CRC_W | Latched CRC4 error count |
| ebit_cnt | output | EBIT_W | Latched far-end error count |
| fas_cnt | output | FAS_W | Latched alignment-word error count |

## Verification
Some properties are checked on every cycle by assertions:
- Interval ends occur only on a frame tick and never in two cycles in a row.
- A saturated running count stays at its maximum.
- A holding register changes only at an interval end, and then takes the running value.
- In violation-only mode every strobe is counted; in code-violation mode two opposite-polarity strobes in a row never count.

Other behaviour can only be shown by the bench's reference model, compared on every clock across mixed scenarios:
- the exact totals over whole intervals;
- the choice between interval lengths;
- the gating by multiframe sync;
- events landing on the latch cycle.

// File: rtl/e1pc_pkg.sv
package e1pc_pkg;
   typedef enum logic {MODE_BPV = 1'b0, MODE_CV = 1'b1} viol_mode_e;
   typedef enum logic {INTV_LONG = 1'b0, INTV_SHORT = 1'b1} intv_sel_e;
endpackage

// File: rtl/e1pc_interval_timer.sv
module e1pc_interval_timer #(
   parameter int SHORT_FRAMES = 500,
   parameter int LONG_FRAMES  = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic short_intv,
   output logic latch_o
);
   import e1pc_pkg::*;
   localparam int CW = $clog2(LONG_FRAMES + 1);
   localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_FRAMES - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_FRAMES - 1);

   generate
      if (SHORT_FRAMES < 2 || LONG_FRAMES <= SHORT_FRAMES) begin : g_bad_cfg
         $error("interval lengths: need 2 <= SHORT_FRAMES < LONG_FRAMES");
      end
   endgenerate

   logic [CW-1:0] frames_q;
   logic [CW-1:0] last_idx;
   intv_sel_e     sel;

   assign sel      = intv_sel_e'(short_intv);
   assign last_idx = (sel == INTV_SHORT) ? SHORT_LAST : LONG_LAST;
   assign latch_o  = frame_tick && (frames_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          frames_q <= '0;
      else if (latch_o)    frames_q <= '0;
      else if (frame_tick) frames_q <= frames_q + 1'b1;
   end

   a_r6_latch_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o |-> frame_tick);
   a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o |=> !latch_o);
   a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      frames_q <= LONG_LAST);
endmodule

// File: rtl/e1pc_viol_class.sv
module e1pc_viol_class (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_stb,
   input  logic viol_neg,
   input  logic cv_mode,
   output logic count_o
);
   import e1pc_pkg::*;
   logic       seen_q;
   logic       pol_q;
   viol_mode_e mode;

   assign mode = viol_mode_e'(cv_mode);

   always_comb begin
      unique case (mode)
         MODE_BPV: count_o = viol_stb;
         MODE_CV:  count_o = viol_stb && seen_q && (pol_q == viol_neg);
         default:  count_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         pol_q  <= 1'b0;
      end else if (viol_stb) begin
         seen_q <= 1'b1;
         pol_q  <= viol_neg;
      end
   end

   a_r2_every_bpv: assert property (@(posedge clk) disable iff (!rst_n)
      (!cv_mode && viol_stb) |-> count_o);
   a_r3_alternating_not_cv: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_mode && viol_stb && $past(viol_stb) && ($past(viol_neg) != viol_neg)) |-> !count_o);
   a_r3_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      count_o |-> viol_stb);
endmodule

// File: rtl/e1pc_sat_counter.sv
module e1pc_sat_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         latch,
   input  logic         inc,
   output logic [W-1:0] hold_o
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 1) begin : g_bad_w
         $error("counter width must be at least 1");
      end
   endgenerate

   logic [W-1:0] acc_q;
   logic [W-1:0] acc_plus;

   generate
      if (SATURATE) begin : g_sat
         assign acc_plus = (acc_q == TOP) ? acc_q : acc_q + 1'b1;
      end else begin : g_wrap
         assign acc_plus = acc_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         hold_o <= '0;
      end else if (latch) begin
         hold_o <= acc_q;
         acc_q  <= W'(inc);
      end else if (inc) begin
         acc_q  <= acc_plus;
      end
   end

   generate
      if (SATURATE) begin : g_sat_chk
         a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch && acc_q == TOP) |=> acc_q == TOP);
      end
   endgenerate
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> acc_q <= W'(1));
   a_r6_copy_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> hold_o == $past(acc_q));
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(hold_o));
endmodule

// File: rtl/e1_perf_counters.sv
module e1_perf_counters #(
   parameter int VIOL_W       = 16,
   parameter int CRC_W        = 10,
   parameter int EBIT_W       = 10,
   parameter int FAS_W        = 12,
   parameter int SHORT_FRAMES = 500,
   parameter int LONG_FRAMES  = 8000,
   parameter bit SATURATE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              short_intv,
   input  logic              cv_mode,
   input  logic              crc_mf_sync,
   input  logic              viol_stb,
   input  logic              viol_neg,
   input  logic              crc_err_stb,
   input  logic              ebit_err_stb,
   input  logic              fas_err_stb,
   output logic [VIOL_W-1:0] viol_cnt,
   output logic [CRC_W-1:0]  crc_cnt,
   output logic [EBIT_W-1:0] ebit_cnt,
   output logic [FAS_W-1:0]  fas_cnt
);
   logic latch;
   logic viol_inc;
   logic crc_inc;
   logic ebit_inc;

   e1pc_interval_timer #(.SHORT_FRAMES(SHORT_FRAMES), .LONG_FRAMES(LONG_FRAMES)) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .short_intv(short_intv), .latch_o(latch));

   e1pc_viol_class u_vclass (
      .clk(clk), .rst_n(rst_n), .viol_stb(viol_stb), .viol_neg(viol_neg),
      .cv_mode(cv_mode), .count_o(viol_inc));

   assign crc_inc  = crc_err_stb  && crc_mf_sync;
   assign ebit_inc = ebit_err_stb && crc_mf_sync;

   e1pc_sat_counter #(.W(VIOL_W), .SATURATE(SATURATE)) u_viol (
      .clk(clk), .rst_n(rst_n), .latch(latch), .inc(viol_inc), .hold_o(viol_cnt));
   e1pc_sat_counter #(.W(CRC_W), .SATURATE(SATURATE)) u_crc (
      .clk(clk), .rst_n(rst_n), .latch(latch), .inc(crc_inc), .hold_o(crc_cnt));
   e1pc_sat_counter #(.W(EBIT_W), .SATURATE(SATURATE)) u_ebit (
      .clk(clk), .rst_n(rst_n), .latch(latch), .inc(ebit_inc), .hold_o(ebit_cnt));
   e1pc_sat_counter #(.W(FAS_W), .SATURATE(SATURATE)) u_fas (
      .clk(clk), .rst_n(rst_n), .latch(latch), .inc(fas_err_stb), .hold_o(fas_cnt));

   a_r5_gate_far_end: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_mf_sync |-> !(crc_inc || ebit_inc));
   a_r4_viol_ignores_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (!cv_mode && viol_stb && !crc_mf_sync) |-> viol_inc);
endmodule

// File: tb/test_e1_perf_counters.sv
module test_e1_perf_counters;
   localparam int VW = 6, CW = 4, EW = 4, FW = 5, SF = 6, LF = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_tick = 0, short_intv = 0, cv_mode = 0, crc_mf_sync = 1;
   logic viol_stb = 0, viol_neg = 0, crc_err_stb = 0, ebit_err_stb = 0, fas_err_stb = 0;
   logic [VW-1:0] viol_cnt;
   logic [CW-1:0] crc_cnt;
   logic [EW-1:0] ebit_cnt;
   logic [FW-1:0] fas_cnt;

   always #4 clk = ~clk;

   e1_perf_counters #(.VIOL_W(VW), .CRC_W(CW), .EBIT_W(EW), .FAS_W(FW),
      .SHORT_FRAMES(SF), .LONG_FRAMES(LF)) i_e1_perf_counters (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .short_intv(short_intv),
      .cv_mode(cv_mode), .crc_mf_sync(crc_mf_sync), .viol_stb(viol_stb),
      .viol_neg(viol_neg), .crc_err_stb(crc_err_stb), .ebit_err_stb(ebit_err_stb),
      .fas_err_stb(fas_err_stb), .viol_cnt(viol_cnt), .crc_cnt(crc_cnt),
      .ebit_cnt(ebit_cnt), .fas_cnt(fas_cnt));

   int checks = 0, errors = 0;
   string cur_req = "R1";
   int acc[4], hold[4], maxv[4];
   int frames = 0;
   bit seen = 0, lastpol = 0;
   logic [15:0] lf = 16'hACE1;

   initial begin
      maxv[0] = (1 << VW) - 1; maxv[1] = (1 << CW) - 1;
      maxv[2] = (1 << EW) - 1; maxv[3] = (1 << FW) - 1;
   end

   // reference model: interval bookkeeping with plain integers
   always @(posedge clk) begin
      int inc[4];
      bit lat;
      if (!rst_n) begin
         foreach (acc[i]) begin acc[i] = 0; hold[i] = 0; end
         frames = 0; seen = 0; lastpol = 0;
      end else begin
         inc[0] = (viol_stb && (!cv_mode || (seen && lastpol == viol_neg))) ? 1 : 0;
         inc[1] = (crc_err_stb && crc_mf_sync) ? 1 : 0;
         inc[2] = (ebit_err_stb && crc_mf_sync) ? 1 : 0;
         inc[3] = fas_err_stb ? 1 : 0;
         if (viol_stb) begin seen = 1; lastpol = viol_neg; end
         lat = frame_tick && (frames + 1 >= (short_intv ? SF : LF));
         if (lat) begin
            foreach (acc[i]) begin hold[i] = acc[i]; acc[i] = inc[i]; end
            frames = 0;
         end else begin
            foreach (acc[i]) if (acc[i] + inc[i] <= maxv[i]) acc[i] = acc[i] + inc[i];
            if (frame_tick) frames = frames + 1;
         end
      end
   end

   task automatic cmp(string nm, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cmp("viol_cnt", int'(viol_cnt), hold[0]);
      cmp("crc_cnt",  int'(crc_cnt),  hold[1]);
      cmp("ebit_cnt", int'(ebit_cnt), hold[2]);
      cmp("fas_cnt",  int'(fas_cnt),  hold[3]);
   end

   task automatic step_lfsr();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // kind: 0 random strobes, 1 alternating polarity every cycle,
   // 2 same polarity every cycle, 3 all strobes every cycle
   task automatic run(int n, int tick_every, int kind);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         step_lfsr();
         frame_tick = (c % tick_every) == 0;
         case (kind)
            0: begin
               viol_stb = lf[0]; viol_neg = lf[3]; crc_err_stb = lf[5];
               ebit_err_stb = lf[7]; fas_err_stb = lf[9] & lf[1];
            end
            1: begin viol_stb = 1; viol_neg = c[0]; crc_err_stb = 0; ebit_err_stb = 0; fas_err_stb = 0; end
            2: begin viol_stb = 1; viol_neg = 1; crc_err_stb = 0; ebit_err_stb = 0; fas_err_stb = 0; end
            default: begin viol_stb = 1; viol_neg = lf[2]; crc_err_stb = 1; ebit_err_stb = 1; fas_err_stb = 1; end
         endcase
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(10, 4, 0);                       // R1 before the first interval ends
      cur_req = "R2"; short_intv = 1; cv_mode = 0;
      run(200, 4, 0);
      cur_req = "R3"; cv_mode = 1;
      run(200, 4, 0);
      run(80, 4, 1);                       // R3: opposite polarity pairs never count
      run(80, 4, 2);                       // R3: same polarity pairs all count
      cur_req = "R4 R5"; crc_mf_sync = 0; cv_mode = 0;
      run(200, 4, 0);
      crc_mf_sync = 1;
      cur_req = "R6"; short_intv = 0;
      run(300, 4, 0);
      short_intv = 1;
      run(100, 3, 0);                      // R6: switch back to short interval
      cur_req = "R8"; short_intv = 0;
      run(250, 4, 3);
      cur_req = "R7"; short_intv = 1;
      run(100, 1, 3);                      // R7: strobes land on every latch cycle
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule